// File: doc/BRIEF.md
# Dual Wiper Register with Zero-Crossing Update

This block keeps two wiper positions for a stereo attenuator, one for the left channel and one for the right. Each position is a 5-bit value that selects one of 32 taps through a one-hot select bus. A command interface can set a position outright or move it one tap up or down. Every command carries a flag for each channel, so it can address one channel or both at the same time.

Each command also carries a zero-detect flag. When the flag is clear, the new position reaches the tap select bus on the same clock edge that accepts the command. When the flag is set, the new position is accepted and can be read back at once. The tap select bus keeps its old line until a near-zero-amplitude pulse arrives for that channel, so an audio level step never lands mid-waveform. The pulse comes from an analog detector outside this block. If no pulse arrives, a hold limit applies the pending position after a fixed number of clocks, so the wiper cannot stall.

The read-back outputs always show the accepted position, including a pending one. The tap buses show the position actually applied.

Top module: `dual_wiper_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, both read-back values are 0 and both tap buses have only bit 0 set (mute).
- R2: Each tap bus always has exactly one bit set, and that bit's index is the applied position of that channel.
- R3: A command is accepted on a clock edge where `req_valid` is 1. `req_op` 2'b00 loads `req_data`, 2'b01 adds one, 2'b10 subtracts one, and 2'b11 is reserved: that command changes nothing on either channel.
- R4: `req_left` and `req_right` select the channels a command acts on. Both may be set together. A channel whose flag is clear keeps its read-back value and its tap bus.
- R5: Adding one at position 31 leaves 31. Subtracting one at position 0 leaves 0. The value never wraps.
- R6: With `req_zd` = 0, the tap bus of each selected channel shows the new position in the cycle after the accepting edge, together with the read-back value.
- R7: With `req_zd` = 1, the read-back value changes right away. The tap bus keeps its old line until a `zc_left`/`zc_right` pulse for that channel is seen, and then it shows the read-back value one cycle later. A pulse on the other channel, or a pulse when nothing is pending, changes nothing.
- R8: A pending position with no zero-crossing pulse is applied on the 65,536th clock edge after the edge that accepted it (parameter `HOLD_LIMIT`).
- R9: A new command to a channel that has a pending position replaces the pending value and restarts the hold count. A zero-crossing pulse in the same cycle as that command is ignored.
- R10: Add and subtract act on the read-back value, which includes any pending value. Repeated steps therefore accumulate while the tap bus stays put.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Command present this cycle |
| req_op | input | 2 | 00 load, 01 up, 10 down, 11 reserved |
| req_data | input | 5 | Position for a load |
| req_left | input | 1 | Command acts on the left channel |
| req_right | input | 1 | Command acts on the right channel |
| req_zd | input | 1 | Defer the tap change until a zero crossing |
| zc_left | input | 1 | Near-zero-amplitude pulse, left channel |
| zc_right | input | 1 | Near-zero-amplitude pulse, right channel |
| tap_left | output | 32 | One-hot tap select, left channel |
| tap_right | output | 32 | One-hot tap select, right channel |
| rd_left | output | 5 | Accepted left position, including a pending one |
| rd_right | output | 5 | Accepted right position, including a pending one |

## Verification
The bench runs the following command patterns:
- Loads, single steps and runs of steps with deferral off. These show that the read-back value and the tap bus move together.
- The same steps with deferral on. Here the read-back value must move while the tap bus holds, which separates the two paths.
- One-channel and two-channel selections, and pulses on the wrong channel. These show whether channel state is shared.
- Steps at both ends of the range, and a second command arriving during a long wait. These separate wrap from saturate, and a restarted hold count from one that keeps running.

// File: rtl/dual_wiper_ctl.sv
module dual_wiper_ctl #(
  parameter int WIDTH      = 5,
  parameter int HOLD_LIMIT = 65536
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [1:0]              req_op,
  input  logic [WIDTH-1:0]        req_data,
  input  logic                    req_left,
  input  logic                    req_right,
  input  logic                    req_zd,
  input  logic                    zc_left,
  input  logic                    zc_right,
  output logic [(1<<WIDTH)-1:0]   tap_left,
  output logic [(1<<WIDTH)-1:0]   tap_right,
  output logic [WIDTH-1:0]        rd_left,
  output logic [WIDTH-1:0]        rd_right
);

  localparam int TAPS = 1 << WIDTH;
  localparam int CW   = (HOLD_LIMIT > 1) ? $clog2(HOLD_LIMIT) : 1;
  localparam logic [WIDTH-1:0] TOP  = '1;
  localparam logic [CW-1:0]    LAST = CW'(HOLD_LIMIT - 1);

  logic [TAPS-1:0]  tap_vec [2];
  logic [WIDTH-1:0] rd_vec  [2];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic             sel, zc, hit;
    logic [WIDTH-1:0] tgt, app, nxt;
    logic             pend;
    logic [CW-1:0]    cnt;

    assign sel = (c == 0) ? req_left : req_right;
    assign zc  = (c == 0) ? zc_left  : zc_right;
    assign hit = req_valid && sel && (req_op != 2'b11);

    always_comb begin
      case (req_op)
        2'b00:   nxt = req_data;
        2'b01:   nxt = (tgt == TOP)   ? tgt : tgt + 1'b1;
        2'b10:   nxt = (tgt == '0)    ? tgt : tgt - 1'b1;
        default: nxt = tgt;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tgt  <= '0;
        app  <= '0;
        pend <= 1'b0;
        cnt  <= '0;
      end else if (hit) begin
        tgt <= nxt;
        cnt <= '0;
        if (!req_zd || nxt == app) begin
          app  <= nxt;
          pend <= 1'b0;
        end else begin
          pend <= 1'b1;
        end
      end else if (pend) begin
        if (zc || cnt == LAST) begin
          app  <= tgt;
          pend <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign tap_vec[c] = {{(TAPS-1){1'b0}}, 1'b1} << app;
    assign rd_vec[c]  = tgt;
  end

  assign tap_left  = tap_vec[0];
  assign tap_right = tap_vec[1];
  assign rd_left   = rd_vec[0];
  assign rd_right  = rd_vec[1];

endmodule

// File: rtl/dual_wiper_ctl_chk.sv
module dual_wiper_ctl_chk #(
  parameter int WIDTH = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic [1:0]            req_op,
  input logic                  req_left,
  input logic                  req_right,
  input logic                  req_zd,
  input logic                  zc_left,
  input logic                  zc_right,
  input logic [(1<<WIDTH)-1:0] tap_left,
  input logic [(1<<WIDTH)-1:0] tap_right,
  input logic [WIDTH-1:0]      rd_left,
  input logic [WIDTH-1:0]      rd_right
);
  localparam int TAPS = 1 << WIDTH;
  localparam logic [WIDTH-1:0] TOP = '1;

  logic hit_l, hit_r;
  assign hit_l = req_valid && req_left  && req_op != 2'b11;
  assign hit_r = req_valid && req_right && req_op != 2'b11;

  assert_mute_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (rd_left == '0 && rd_right == '0 &&
                tap_left == TAPS'(1) && tap_right == TAPS'(1)));

  assert_tap_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_left) == 1 && $countones(tap_right) == 1);

  assert_unselected_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_left) |=> $stable(rd_left));

  assert_unselected_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_right) |=> $stable(rd_right));

  assert_saturate_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_l && req_op == 2'b01 && rd_left == TOP) |=> rd_left == TOP);

  assert_saturate_bottom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_r && req_op == 2'b10 && rd_right == '0) |=> rd_right == '0);

  assert_immediate_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_l && !req_zd) |=> tap_left == (TAPS'(1) << rd_left));

  assert_immediate_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_r && !req_zd) |=> tap_right == (TAPS'(1) << rd_right));

  assert_zc_applies_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_left && !hit_l) |=> tap_left == (TAPS'(1) << rd_left));

  assert_zc_applies_right_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_right && !hit_r) |=> tap_right == (TAPS'(1) << rd_right));
endmodule

bind dual_wiper_ctl dual_wiper_ctl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_left(req_left), .req_right(req_right), .req_zd(req_zd),
  .zc_left(zc_left), .zc_right(zc_right),
  .tap_left(tap_left), .tap_right(tap_right),
  .rd_left(rd_left), .rd_right(rd_right)
);

// File: tb/dual_wiper_ctl_tb.sv
module dual_wiper_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [4:0]  req_data = '0;
  logic        req_left = 1'b0, req_right = 1'b0, req_zd = 1'b0;
  logic        zc_left = 1'b0, zc_right = 1'b0;
  logic [31:0] tap_left, tap_right;
  logic [4:0]  rd_left, rd_right;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_wiper_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_data(req_data), .req_left(req_left), .req_right(req_right),
    .req_zd(req_zd), .zc_left(zc_left), .zc_right(zc_right),
    .tap_left(tap_left), .tap_right(tap_right),
    .rd_left(rd_left), .rd_right(rd_right)
  );

  localparam logic [1:0] OP_LD = 2'b00, OP_UP = 2'b01, OP_DN = 2'b10, OP_RSV = 2'b11;

  function automatic logic [31:0] oh(input logic [4:0] v);
    return 32'd1 << v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [4:0] d,
                     input logic l, input logic r, input logic zd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_data = d;
    req_left = l; req_right = r; req_zd = zd;
    @(negedge clk);
    req_valid = 1'b0; req_left = 1'b0; req_right = 1'b0; req_zd = 1'b0;
  endtask

  task automatic pulse(input logic l, input logic r);
    @(negedge clk);
    zc_left = l; zc_right = r;
    @(negedge clk);
    zc_left = 1'b0; zc_right = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 rd_left", 32'(rd_left), 0);
    check("R1 rd_right", 32'(rd_right), 0);
    check("R1 tap_left", tap_left, 32'd1);
    check("R1 tap_right", tap_right, 32'd1);
  endtask

  task automatic t_load_immediate;
    cmd(OP_LD, 5'd17, 1, 0, 0);
    check("R3 load rd_left", 32'(rd_left), 17);
    check("R6 R2 load tap_left", tap_left, oh(17));
    check("R4 right untouched", tap_right, oh(0));
    cmd(OP_LD, 5'd9, 1, 1, 0);
    check("R4 both rd_left", 32'(rd_left), 9);
    check("R4 both rd_right", 32'(rd_right), 9);
    check("R6 both tap_right", tap_right, oh(9));
  endtask

  task automatic t_steps;
    cmd(OP_UP, 5'd0, 1, 0, 0);
    check("R3 up rd_left", 32'(rd_left), 10);
    check("R6 up tap_left", tap_left, oh(10));
    cmd(OP_DN, 5'd0, 0, 1, 0);
    check("R3 down rd_right", 32'(rd_right), 8);
    check("R4 left kept", 32'(rd_left), 10);
    cmd(OP_RSV, 5'd3, 1, 1, 0);
    check("R3 reserved rd_left", 32'(rd_left), 10);
    check("R3 reserved tap_right", tap_right, oh(8));
  endtask

  task automatic t_saturate;
    cmd(OP_LD, 5'd31, 1, 0, 0);
    cmd(OP_LD, 5'd0, 0, 1, 0);
    cmd(OP_UP, 5'd0, 1, 0, 0);
    check("R5 top rd_left", 32'(rd_left), 31);
    check("R5 top tap_left", tap_left, oh(31));
    cmd(OP_DN, 5'd0, 0, 1, 0);
    check("R5 bottom rd_right", 32'(rd_right), 0);
    check("R5 bottom tap_right", tap_right, oh(0));
  endtask

  task automatic t_zero_detect;
    cmd(OP_LD, 5'd4, 1, 1, 0);
    cmd(OP_LD, 5'd20, 1, 1, 1);
    check("R7 rd_left new", 32'(rd_left), 20);
    check("R7 tap_left held", tap_left, oh(4));
    check("R7 tap_right held", tap_right, oh(4));
    pulse(0, 1);
    check("R7 right applied", tap_right, oh(20));
    check("R7 other zc no effect", tap_left, oh(4));
    pulse(1, 0);
    check("R7 left applied", tap_left, oh(20));
    pulse(1, 1);
    check("R7 idle zc no effect", tap_left, oh(20));
  endtask

  task automatic t_accumulate;
    cmd(OP_UP, 5'd0, 1, 0, 1);
    cmd(OP_UP, 5'd0, 1, 0, 1);
    cmd(OP_UP, 5'd0, 1, 0, 1);
    check("R10 rd accumulates", 32'(rd_left), 23);
    check("R10 tap held", tap_left, oh(20));
    pulse(1, 0);
    check("R10 applied sum", tap_left, oh(23));
  endtask

  task automatic t_zc_same_cycle;
    @(negedge clk);
    req_valid = 1'b1; req_op = OP_LD; req_data = 5'd2;
    req_left = 1'b1; req_right = 1'b0; req_zd = 1'b1; zc_left = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_left = 1'b0; req_zd = 1'b0; zc_left = 1'b0;
    check("R9 same-cycle zc ignored", tap_left, oh(23));
    check("R9 rd new", 32'(rd_left), 2);
    pulse(1, 0);
    check("R9 later zc applies", tap_left, oh(2));
  endtask

  task automatic t_hold_restart;
    cmd(OP_LD, 5'd11, 0, 1, 0);
    cmd(OP_LD, 5'd25, 0, 1, 1);
    wait_cyc(40000);
    check("R8 still pending", tap_right, oh(11));
    cmd(OP_LD, 5'd13, 0, 1, 1);
    check("R9 replaced rd", 32'(rd_right), 13);
    wait_cyc(65535);
    check("R9 restart held", tap_right, oh(11));
    wait_cyc(1);
    check("R8 hold limit applies", tap_right, oh(13));
  endtask

  initial begin
    wait_cyc(3);
    t_reset;
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset;
    t_load_immediate;
    t_steps;
    t_saturate;
    t_zero_detect;
    t_accumulate;
    t_zc_same_cycle;
    t_hold_restart;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule